// File: doc/BRIEF.md
# Credit-Based Virtual-Channel Link

This block holds both ends of one point-to-point link whose single flit wire is shared by several virtual channels. Each channel has its own input stream on the sending side. A message arrives as a sequence of payload words, and the sender labels each word as a head, body, tail or single flit as it crosses the wire. A flit may leave on a channel only while the sender holds a credit for that channel. Each credit stands for one free slot in that channel's receive buffer. Every counter starts full, at the buffer depth.

The receiving side gives each channel its own small FIFO and presents the oldest flit of each channel on a separate output stream. Whenever a flit is drained from a channel's buffer, a one-cycle credit pulse for that channel goes back to the sender. When more than one channel has a word waiting and a credit in hand, a round-robin pointer decides which one uses the wire in that cycle. Because of this, a channel whose consumer has stopped holds only its own credits and never holds the wire.

Back-pressure rules for the streams:
- On the input side, `in_ready[v]` is high only in the cycle in which channel v is granted the wire, and a word moves when valid and ready are both high.
- On the output side, a flit presented with `out_valid[v]` stays put, unchanged, until `out_ready[v]` takes it.

Top module: `vc_link`

## Requirements
- R1: While reset is held and right after it is released, `link_valid`, `out_valid` and `crd_ret` are all low. Each channel's credit count starts at DEPTH, so with no draining a channel can send exactly DEPTH flits.
- R2: A channel never has more than DEPTH flits sent and not yet credited back. When it has DEPTH outstanding, its `in_ready` is low.
- R3: `crd_ret[v]` is high for exactly the one cycle after each cycle in which `out_valid[v]` and `out_ready[v]` were both high, and is low otherwise.
- R4: Flit type codes are 2'b01 head, 2'b00 body, 2'b10 tail and 2'b11 single. The first word of a message is a head, or a single if `in_last` is set. A later word is a tail if `in_last` is set and a body otherwise. The code travels on `link_type` and on the channel's `out_type` field, which is bits [2v+1:2v].
- R5: On a given channel, the flits after a head are bodies until a tail. After a tail or single, the next flit is a head or single, so a message never leaves its channel.
- R6: At most one `in_ready` bit is high in a cycle, and only for a channel with `in_valid` high and a credit. The search starts at the channel after the last one granted, wraps around, and starts at channel 0 after reset.
- R7: A channel whose consumer keeps `out_ready` low does not stop other channels from sending and delivering flits.
- R8: A word accepted on channel v appears on the wire in the next cycle. In that cycle `link_valid` is high, `link_vc` is v and `link_data` holds the word.
- R9: Each channel's output delivers its flits in the order in which they were accepted, with payload intact. `out_valid[v]` rises in the cycle after the flit is on the wire. Channel v's payload is bits [DATA_W*v+DATA_W-1:DATA_W*v] of `in_data` and `out_data`.
- R10: While `out_valid[v]` is high and `out_ready[v]` is low, the next cycle still shows `out_valid[v]` high with the same `out_data` field.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | NUM_VC | Per-channel word valid |
| in_ready | output | NUM_VC | Per-channel word accepted (grant) |
| in_data | input | NUM_VC*DATA_W | Per-channel payload words |
| in_last | input | NUM_VC | Word ends its message |
| link_valid | output | 1 | A flit is on the shared wire |
| link_vc | output | VC_W | Channel number of the wire flit |
| link_type | output | 2 | Type code of the wire flit |
| link_data | output | DATA_W | Payload of the wire flit |
| out_valid | output | NUM_VC | Per-channel receive flit valid |
| out_ready | input | NUM_VC | Per-channel consumer ready |
| out_data | output | NUM_VC*DATA_W | Per-channel receive payload |
| out_type | output | NUM_VC*2 | Per-channel receive type code |
| crd_ret | output | NUM_VC | Per-channel credit-return pulse |

## Verification
The hardest situation to reach is a channel that has run out of credits while other channels keep moving. The whole credit loop is inside the block, so this can only be caused by a consumer that stops. The stimulus first fills every buffer with all consumers stalled. It then releases all consumers except one, so that channel stays stuck at zero credits while the round-robin serves the rest. After a full drain it fills again to show that every credit came back. Long random phases then mix message lengths, gaps in the input valid signals and consumer stalls, so that credit pulses, grants and pops land in the same cycles.

// File: rtl/vc_link_pkg.sv
`timescale 1ns/1ps
package vc_link_pkg;
  typedef enum logic [1:0] {
    FK_BODY   = 2'b00,
    FK_HEAD   = 2'b01,
    FK_TAIL   = 2'b10,
    FK_SINGLE = 2'b11
  } flit_kind_e;

  // in_msg: a message on this channel is open; last: word closes it
  function automatic flit_kind_e frame_kind(input logic in_msg, input logic last);
    if (in_msg) return last ? FK_TAIL : FK_BODY;
    return last ? FK_SINGLE : FK_HEAD;
  endfunction
endpackage

// File: rtl/vc_lane_fifo.sv
`timescale 1ns/1ps
module vc_lane_fifo #(
  parameter int DEPTH = 2,
  parameter int WIDTH = 18
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             push,
  input  logic [WIDTH-1:0] din,
  input  logic             pop,
  output logic [WIDTH-1:0] dout,
  output logic             not_empty
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);

  logic [WIDTH-1:0] mem [DEPTH];
  logic [AW-1:0]    wp_q, rp_q;
  logic [CW-1:0]    cnt_q;

  function automatic logic [AW-1:0] bump(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + AW'(1);
  endfunction

  always_ff @(posedge clk) begin
    if (push) mem[wp_q] <= din;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wp_q  <= '0;
      rp_q  <= '0;
      cnt_q <= '0;
    end else begin
      if (push) wp_q <= bump(wp_q);
      if (pop)  rp_q <= bump(rp_q);
      case ({push, pop})
        2'b10:   cnt_q <= cnt_q + CW'(1);
        2'b01:   cnt_q <= cnt_q - CW'(1);
        default: cnt_q <= cnt_q;
      endcase
    end
  end

  assign dout      = mem[rp_q];
  assign not_empty = (cnt_q != '0);
endmodule

// File: rtl/vc_credit_ctr.sv
`timescale 1ns/1ps
module vc_credit_ctr #(
  parameter int DEPTH = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic spend,
  input  logic refund,
  output logic has_credit
);
  localparam int CW = $clog2(DEPTH + 1);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= CW'(DEPTH);
    end else begin
      case ({spend, refund})
        2'b10:   cnt_q <= cnt_q - CW'(1);
        2'b01:   cnt_q <= cnt_q + CW'(1);
        default: cnt_q <= cnt_q;
      endcase
    end
  end

  assign has_credit = (cnt_q != '0);
endmodule

// File: rtl/vc_rr_arb.sv
`timescale 1ns/1ps
module vc_rr_arb #(
  parameter int N     = 3,
  parameter int IDX_W = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [N-1:0]     req,
  output logic [N-1:0]     gnt,
  output logic [IDX_W-1:0] gnt_idx
);
  logic [IDX_W-1:0] ptr_q;
  logic             any;
  int               win;

  always_comb begin
    gnt = '0;
    any = 1'b0;
    win = 0;
    for (int i = 0; i < N; i++) begin
      int c;
      c = (int'(ptr_q) + i) % N;
      if (!any && req[c]) begin
        any    = 1'b1;
        gnt[c] = 1'b1;
        win    = c;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   ptr_q <= '0;
    else if (any) ptr_q <= IDX_W'((win + 1) % N);
  end

  assign gnt_idx = IDX_W'(win);
endmodule

// File: rtl/vc_link.sv
`timescale 1ns/1ps
module vc_link
  import vc_link_pkg::*;
#(
  parameter int NUM_VC = 3,
  parameter int DATA_W = 16,
  parameter int DEPTH  = 2,
  localparam int VC_W  = (NUM_VC > 1) ? $clog2(NUM_VC) : 1
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic [NUM_VC-1:0]        in_valid,
  output logic [NUM_VC-1:0]        in_ready,
  input  logic [NUM_VC*DATA_W-1:0] in_data,
  input  logic [NUM_VC-1:0]        in_last,
  output logic                     link_valid,
  output logic [VC_W-1:0]          link_vc,
  output logic [1:0]               link_type,
  output logic [DATA_W-1:0]        link_data,
  output logic [NUM_VC-1:0]        out_valid,
  input  logic [NUM_VC-1:0]        out_ready,
  output logic [NUM_VC*DATA_W-1:0] out_data,
  output logic [NUM_VC*2-1:0]      out_type,
  output logic [NUM_VC-1:0]        crd_ret
);
  localparam int LANE_W = DATA_W + 2;

  // ---------------- sending side ----------------
  logic [NUM_VC-1:0] has_credit, req, gnt, in_msg_q;
  logic [VC_W-1:0]   gnt_idx;
  logic [NUM_VC-1:0] crd_q;

  genvar v;
  generate
    for (v = 0; v < NUM_VC; v++) begin : g_credit
      vc_credit_ctr #(.DEPTH(DEPTH)) u_ctr (
        .clk       (clk),
        .rst_n     (rst_n),
        .spend     (gnt[v]),
        .refund    (crd_q[v]),
        .has_credit(has_credit[v])
      );
    end
  endgenerate

  assign req = in_valid & has_credit;

  vc_rr_arb #(.N(NUM_VC), .IDX_W(VC_W)) u_arb (
    .clk    (clk),
    .rst_n  (rst_n),
    .req    (req),
    .gnt    (gnt),
    .gnt_idx(gnt_idx)
  );

  assign in_ready = gnt;

  logic [DATA_W-1:0] sel_data;
  logic              sel_last, sel_msg;

  always_comb begin
    sel_data = '0;
    sel_last = 1'b0;
    sel_msg  = 1'b0;
    for (int i = 0; i < NUM_VC; i++) begin
      if (gnt[i]) begin
        sel_data = in_data[i*DATA_W +: DATA_W];
        sel_last = in_last[i];
        sel_msg  = in_msg_q[i];
      end
    end
  end

  // framing state: a channel is open from head until tail
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      in_msg_q <= '0;
    end else begin
      for (int i = 0; i < NUM_VC; i++)
        if (gnt[i]) in_msg_q[i] <= ~in_last[i];
    end
  end

  // the shared wire register
  logic              wire_v_q;
  logic [VC_W-1:0]   wire_vc_q;
  flit_kind_e        wire_t_q;
  logic [DATA_W-1:0] wire_d_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wire_v_q  <= 1'b0;
      wire_vc_q <= '0;
      wire_t_q  <= FK_BODY;
      wire_d_q  <= '0;
    end else begin
      wire_v_q <= |gnt;
      if (|gnt) begin
        wire_vc_q <= gnt_idx;
        wire_t_q  <= frame_kind(sel_msg, sel_last);
        wire_d_q  <= sel_data;
      end
    end
  end

  assign link_valid = wire_v_q;
  assign link_vc    = wire_vc_q;
  assign link_type  = wire_t_q;
  assign link_data  = wire_d_q;

  // ---------------- receiving side ----------------
  logic [NUM_VC-1:0] pop;

  generate
    for (v = 0; v < NUM_VC; v++) begin : g_lane
      logic [LANE_W-1:0] head;
      vc_lane_fifo #(.DEPTH(DEPTH), .WIDTH(LANE_W)) u_fifo (
        .clk      (clk),
        .rst_n    (rst_n),
        .push     (wire_v_q && (wire_vc_q == VC_W'(v))),
        .din      ({wire_t_q, wire_d_q}),
        .pop      (pop[v]),
        .dout     (head),
        .not_empty(out_valid[v])
      );
      assign pop[v]                        = out_valid[v] & out_ready[v];
      assign out_data[v*DATA_W +: DATA_W]  = head[DATA_W-1:0];
      assign out_type[v*2 +: 2]            = head[LANE_W-1 -: 2];
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) crd_q <= '0;
    else        crd_q <= pop;
  end

  assign crd_ret = crd_q;
endmodule

// File: rtl/vc_link_chk.sv
`timescale 1ns/1ps
module vc_link_chk
  import vc_link_pkg::*;
#(
  parameter int NUM_VC = 3,
  parameter int DATA_W = 16,
  parameter int DEPTH  = 2,
  parameter int VC_W   = 2
) (
  input logic                     clk,
  input logic                     rst_n,
  input logic [NUM_VC-1:0]        in_valid,
  input logic [NUM_VC-1:0]        in_ready,
  input logic                     link_valid,
  input logic [VC_W-1:0]          link_vc,
  input logic [1:0]               link_type,
  input logic [NUM_VC-1:0]        out_valid,
  input logic [NUM_VC-1:0]        out_ready,
  input logic [NUM_VC*DATA_W-1:0] out_data,
  input logic [NUM_VC-1:0]        crd_ret
);
  p_one_grant_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(in_ready) && ((in_ready & ~in_valid) == '0));

  genvar v;
  generate
    for (v = 0; v < NUM_VC; v++) begin : g_vc
      int  outst;
      logic open_q;

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) outst <= 0;
        else outst <= outst + ((in_valid[v] && in_ready[v]) ? 1 : 0) - (crd_ret[v] ? 1 : 0);
      end

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) open_q <= 1'b0;
        else if (link_valid && link_vc == VC_W'(v))
          open_q <= (link_type == FK_HEAD) || (link_type == FK_BODY);
      end

      p_credit_bound_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (outst >= 0) && (outst <= DEPTH));

      p_stall_at_limit_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (outst == DEPTH) |-> !in_ready[v]);

      p_credit_pulse_r3: assert property (@(posedge clk) disable iff (!rst_n)
        crd_ret[v] == $past(out_valid[v] && out_ready[v]));

      p_open_msg_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (link_valid && link_vc == VC_W'(v) && open_q)
          |-> (link_type == FK_BODY || link_type == FK_TAIL));

      p_closed_msg_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (link_valid && link_vc == VC_W'(v) && !open_q)
          |-> (link_type == FK_HEAD || link_type == FK_SINGLE));

      p_to_wire_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid[v] && in_ready[v]) |=> (link_valid && link_vc == VC_W'(v)));

      p_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid[v] && !out_ready[v])
          |=> (out_valid[v] && $stable(out_data[v*DATA_W +: DATA_W])));
    end
  endgenerate
endmodule

bind vc_link vc_link_chk #(
  .NUM_VC(NUM_VC), .DATA_W(DATA_W), .DEPTH(DEPTH), .VC_W(VC_W)
) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .in_valid  (in_valid),
  .in_ready  (in_ready),
  .link_valid(link_valid),
  .link_vc   (link_vc),
  .link_type (link_type),
  .out_valid (out_valid),
  .out_ready (out_ready),
  .out_data  (out_data),
  .crd_ret   (crd_ret)
);

// File: tb/vc_link_tb.sv
`timescale 1ns/1ps
module vc_link_tb;
  localparam int N  = 3;
  localparam int W  = 16;
  localparam int D  = 2;
  localparam int VW = 2;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [N-1:0]   in_valid = '0, in_last = '0, out_ready = '0;
  logic [N*W-1:0] in_data = '0;
  logic [N-1:0]   in_ready, out_valid, crd_ret;
  logic           link_valid;
  logic [VW-1:0]  link_vc;
  logic [1:0]     link_type;
  logic [W-1:0]   link_data;
  logic [N*W-1:0] out_data;
  logic [N*2-1:0] out_type;

  always #10 clk = ~clk;

  vc_link #(.NUM_VC(N), .DATA_W(W), .DEPTH(D)) u_dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_data(in_data), .in_last(in_last), .link_valid(link_valid),
    .link_vc(link_vc), .link_type(link_type), .link_data(link_data),
    .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data),
    .out_type(out_type), .crd_ret(crd_ret)
  );

  int tests = 0, fails = 0;
  bit done = 1'b0;
  int unsigned rs = 32'h1badf00d;

  // reference model state
  int           m_cnt[N];
  int           m_rr;
  bit           m_open[N];
  logic [W+1:0] m_q[N][$];
  bit           m_lv;
  int           m_lvc;
  logic [1:0]   m_lt;
  logic [W-1:0] m_ld;
  bit           m_cret[N];
  int           seq[N], sent[N], deliv[N];

  function automatic int unsigned rnd();
    rs ^= rs << 13; rs ^= rs >> 17; rs ^= rs << 5;
    return rs;
  endfunction

  function automatic logic [1:0] kind(bit open, bit last);
    if (open) return last ? 2'b10 : 2'b00;
    return last ? 2'b11 : 2'b01;
  endfunction

  task automatic chk(bit ok, string rq, string what, longint act, longint exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual=%0h expected=%0h", rq, what, act, exp);
    end
  endtask

  // one cycle: drive, compare against model, advance model past the edge
  task automatic step(int pv, logic [N-1:0] mask, bit rnd_ready);
    int g;
    bit newc[N];
    bit ov[N];
    @(negedge clk);
    for (int v = 0; v < N; v++) begin
      in_valid[v] = (rnd() % 100) < pv;
      in_last[v]  = (rnd() % 3) == 0;
      in_data[v*W +: W] = {4'(v), 12'(seq[v])};
      out_ready[v] = mask[v] & (rnd_ready ? rnd()[0] : 1'b1);
    end
    #2;
    g = -1;
    for (int i = 0; i < N; i++) begin
      int c;
      c = (m_rr + i) % N;
      if (g < 0 && in_valid[c] && m_cnt[c] > 0) g = c;
    end
    for (int v = 0; v < N; v++) begin
      chk(in_ready[v] == (g == v), "R6", "in_ready", in_ready[v], (g == v));
      chk(crd_ret[v] == m_cret[v], "R3", "crd_ret", crd_ret[v], m_cret[v]);
      ov[v] = m_q[v].size() > 0;
      chk(out_valid[v] == ov[v], "R9", "out_valid", out_valid[v], ov[v]);
      if (ov[v]) begin
        // R10 holds because a stalled head must reappear unchanged here
        chk(out_data[v*W +: W] == m_q[v][0][W-1:0], "R9", "out_data",
            out_data[v*W +: W], m_q[v][0][W-1:0]);
        chk(out_type[v*2 +: 2] == m_q[v][0][W+1:W], "R4", "out_type",
            out_type[v*2 +: 2], m_q[v][0][W+1:W]);
      end
    end
    chk(link_valid == m_lv, "R8", "link_valid", link_valid, m_lv);
    if (m_lv) begin
      chk(int'(link_vc) == m_lvc, "R8", "link_vc", link_vc, m_lvc);
      chk(link_data == m_ld, "R8", "link_data", link_data, m_ld);
      chk(link_type == m_lt, "R4", "link_type", link_type, m_lt);
    end
    // state update for the coming edge
    for (int v = 0; v < N; v++) begin
      newc[v] = 1'b0;
      if (ov[v] && out_ready[v]) begin
        void'(m_q[v].pop_front());
        deliv[v]++;
        newc[v] = 1'b1;
      end
    end
    if (m_lv) m_q[m_lvc].push_back({m_lt, m_ld});
    for (int v = 0; v < N; v++) begin
      m_cnt[v] += m_cret[v] ? 1 : 0;
      if (g == v) m_cnt[v]--;
      m_cret[v] = newc[v];
    end
    if (g >= 0) begin
      m_lv  = 1'b1;
      m_lvc = g;
      m_lt  = kind(m_open[g], in_last[g]);
      m_ld  = in_data[g*W +: W];
      m_open[g] = !in_last[g];
      m_rr = (g + 1) % N;
      seq[g]++;
      sent[g]++;
    end else begin
      m_lv = 1'b0;
    end
  endtask

  task automatic clear_counts();
    for (int v = 0; v < N; v++) begin sent[v] = 0; deliv[v] = 0; end
  endtask

  task automatic summary();
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      summary();
      $finish;
    end
  end

  initial begin
    m_rr = 0; m_lv = 1'b0; m_lvc = 0; m_lt = '0; m_ld = '0;
    for (int v = 0; v < N; v++) begin
      m_cnt[v] = D; m_open[v] = 1'b0; m_cret[v] = 1'b0; seq[v] = 0;
    end
    clear_counts();
    repeat (3) @(negedge clk);
    // R1: held in reset
    chk(link_valid == 1'b0, "R1", "link_valid in reset", link_valid, 0);
    chk(out_valid == '0, "R1", "out_valid in reset", out_valid, 0);
    chk(crd_ret == '0, "R1", "crd_ret in reset", crd_ret, 0);
    rst_n = 1'b1;
    repeat (3) step(0, '0, 1'b0);

    // R1/R2: no draining, each channel sends exactly DEPTH flits
    clear_counts();
    repeat (20) step(100, '0, 1'b0);
    for (int v = 0; v < N; v++)
      chk(sent[v] == D, "R1", "flits sent on full credit", sent[v], D);

    // R7: channel 0 consumer stalled, others keep flowing
    clear_counts();
    repeat (60) step(100, 3'b110, 1'b0);
    chk(sent[0] == 0, "R7", "stalled lane sends", sent[0], 0);
    chk(deliv[1] > 10, "R7", "lane 1 deliveries", deliv[1], 11);
    chk(deliv[2] > 10, "R7", "lane 2 deliveries", deliv[2], 11);

    // R2: drain fully, then credits must all be back
    repeat (30) step(0, 3'b111, 1'b0);
    clear_counts();
    repeat (20) step(100, '0, 1'b0);
    for (int v = 0; v < N; v++)
      chk(sent[v] == D, "R2", "credits restored after drain", sent[v], D);

    // random mixes: R4 R5 R6 R8 R9 R10 via the model
    repeat (1500) step(70, 3'b111, 1'b1);
    repeat (1000) step(30, 3'b111, 1'b0);
    repeat (1000) step(100, 3'b101, 1'b1);
    repeat (40) step(0, 3'b111, 1'b0);
    for (int v = 0; v < N; v++)
      chk(out_valid[v] == 1'b0, "R9", "empty after final drain", out_valid[v], 0);

    done = 1'b1;
    summary();
    $finish;
  end
endmodule